// File: doc/BRIEF.md
# Raster-Op Rectangle Fill Engine

This block fills an axis-aligned rectangle of a linear framebuffer with a colour. Instead of overwriting, it applies one of sixteen two-operand logical functions to the fill colour (source) and the pixel already in memory (destination), and writes the result back. A command carries the colour, the top-left X and Y, the width, the height and a raster-operation code. The engine turns each pixel into a byte address. It visits the pixels in row-major order, left to right and then top to bottom. It drives a simple synchronous memory port: one read or one write per cycle, with read data returned one cycle after the read.

Commands arrive on a valid/ready stream. `cmd_ready` is high only while the engine is idle, so back-pressure lasts for the whole of a command. A producer holds `cmd_valid` and the fields until a cycle where both signals are high. Field values presented in any other cycle have no effect. The frame base address, line pitch and pixel-size code are plain configuration inputs, sampled together with the command. `busy`, `done` and `err` are plain status pins.

Operations whose result does not depend on the destination skip the read and write one pixel per cycle. The no-op code completes without touching memory. An unsupported code is rejected with an error flag and causes no memory access.

Top module: `rfe_rect_fill`

## Requirements
- R1: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high exactly while the engine is idle. Command and configuration fields presented at any other time have no effect on memory or flags.
- R2: For a code c in 0..15, each result bit equals bit `{~s,~d}` of c, where s is the colour bit and d is the destination bit. This gives 0:clear, 1:s&d, 2:s&~d, 3:s, 4:~s&d, 5:d, 6:s^d, 7:s|d, 8:~(s|d), 9:~(s^d), 10:~d, 11:s|~d, 12:~s, 13:~s|d, 14:~(s&d), 15:all ones.
- R3: The pixel at column i and row j of the rectangle is at byte address base + (Y+j)*pitch + (X+i)*B. B is 1, 2 or 4 bytes for `cfg_pix_size` 0, 1 and 2, and size code 3 also means 4 bytes. Pixel data is little-endian and right-aligned in the data bus. Only the low B bytes of a pixel are read or written.
- R4: A supported, non-empty, non-no-op command writes every pixel of the rectangle exactly once, in row-major order, and writes nothing else (w*h writes).
- R5: A code of 16 or more makes `done` and `err` high together in the cycle after acceptance, with no memory read or write.
- R6: A width or a height of zero makes `done` high in the cycle after acceptance, with `err` low and no memory access.
- R7: Code 5 (destination unchanged) makes `done` high in the cycle after acceptance, with no memory access.
- R8: Codes 0, 3, 12 and 15 issue no reads and one write per cycle. For N pixels, `done` is high in the (N+1)-th cycle after acceptance.
- R9: All other supported codes read and then write each pixel, with one read outstanding at a time and the read data taken one cycle after the read. For N pixels, `done` is high in the (2N+1)-th cycle after acceptance.
- R10: `done` is a one-cycle pulse. `busy` is high from the cycle after acceptance through the `done` cycle, and low in the cycle after `done`.
- R11: After reset, `cmd_ready` is high and `busy`, `done`, `err`, `mem_rd_en` and `mem_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_color | input | DATA_W | Fill colour (source operand) |
| cmd_x | input | COORD_W | Left column of the rectangle |
| cmd_y | input | COORD_W | Top row of the rectangle |
| cmd_w | input | COORD_W | Width in pixels |
| cmd_h | input | COORD_W | Height in rows |
| cmd_rop | input | OP_W | Raster-operation code |
| cfg_base | input | ADDR_W | Byte address of pixel (0,0) |
| cfg_pitch | input | ADDR_W | Bytes from one row to the next |
| cfg_pix_size | input | 2 | Pixel-size code (1, 2, 4, 4 bytes) |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data, pixel right-aligned |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the read |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported code, high with done |

## Verification
Counted from the accepting edge, `done` is due in cycle 1 for rejected, empty and no-op commands. It is due in cycle N+1 for destination-independent codes and in cycle 2N+1 for read-modify-write codes. The bench counts falling edges after the accepting edge and compares the cycle where `done` appears with that figure. Between acceptance and `done` it also confirms `busy` high and `cmd_ready` low. The memory image and the read and write counts are compared one falling edge after `done`, when the final write has landed in the bench's memory. The sweep runs all sixteen codes at every pixel-size code over rectangles of varied position and shape. It adds rejected codes, zero extents and a producer that keeps offering junk fields while the engine is busy.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } fill_state_e;

  localparam int unsigned NUM_CODES = 16;
  localparam logic [3:0] CODE_KEEP_DST = 4'h5;

  // A code ignores the destination when both source halves of its
  // truth table are constant with respect to the destination bit.
  function automatic logic code_reads_dst(input logic [3:0] code);
    return (code[0] != code[1]) || (code[2] != code[3]);
  endfunction

  function automatic logic [2:0] size_to_bytes(input logic [1:0] sel);
    logic [2:0] nb;
    case (sel)
      2'd0:    nb = 3'd1;
      2'd1:    nb = 3'd2;
      default: nb = 3'd4;
    endcase
    return nb;
  endfunction

endpackage

// File: rtl/rfe_logic_unit.sv
module rfe_logic_unit #(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        code,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  output logic [DATA_W-1:0] res
);

  // Each bit indexes the 4-entry truth table held in the code.
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    logic [1:0] sel;
    assign sel     = {~src[gi], ~dst[gi]};
    assign res[gi] = code[sel];
  end

endmodule

// File: rtl/rfe_walker.sv
module rfe_walker #(
  parameter int ADDR_W  = 16,
  parameter int COORD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  pitch,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [COORD_W-1:0] w,
  input  logic [COORD_W-1:0] h,
  input  logic [2:0]         nbytes,
  output logic [ADDR_W-1:0]  addr,
  output logic               last
);

  localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

  logic [COORD_W-1:0] col_q, row_q, w_q, h_q;
  logic [ADDR_W-1:0]  pitch_q, addr_q, row_addr_q;
  logic [2:0]         nbytes_q;
  logic [ADDR_W-1:0]  start_addr;
  logic               row_end;

  assign start_addr = base + ADDR_W'(y) * pitch + ADDR_W'(x) * ADDR_W'(nbytes);
  assign row_end    = (col_q == w_q - ONE);
  assign last       = row_end && (row_q == h_q - ONE);
  assign addr       = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q      <= '0;
      row_q      <= '0;
      w_q        <= '0;
      h_q        <= '0;
      pitch_q    <= '0;
      nbytes_q   <= 3'd1;
      addr_q     <= '0;
      row_addr_q <= '0;
    end else if (load) begin
      col_q      <= '0;
      row_q      <= '0;
      w_q        <= w;
      h_q        <= h;
      pitch_q    <= pitch;
      nbytes_q   <= nbytes;
      addr_q     <= start_addr;
      row_addr_q <= start_addr;
    end else if (step) begin
      if (row_end) begin
        col_q      <= '0;
        row_q      <= row_q + ONE;
        row_addr_q <= row_addr_q + pitch_q;
        addr_q     <= row_addr_q + pitch_q;
      end else begin
        col_q  <= col_q + ONE;
        addr_q <= addr_q + ADDR_W'(nbytes_q);
      end
    end
  end

  // R4: the walk never leaves the rectangle.
  p_inside_rect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (col_q < w_q) && (row_q < h_q));

  // R3: inside a row, consecutive pixels are one pixel size apart.
  p_row_stride_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !row_end && !load) |=> (addr_q == $past(addr_q) + ADDR_W'($past(nbytes_q))));

  // R3: a new row starts one pitch below the previous row start.
  p_line_stride_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && row_end && !load) |=> (addr_q == $past(row_addr_q) + $past(pitch_q)));

endmodule

// File: rtl/rfe_rect_fill.sv
module rfe_rect_fill #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16,
  parameter int COORD_W = 8,
  parameter int OP_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [DATA_W-1:0]  cmd_color,
  input  logic [COORD_W-1:0] cmd_x,
  input  logic [COORD_W-1:0] cmd_y,
  input  logic [COORD_W-1:0] cmd_w,
  input  logic [COORD_W-1:0] cmd_h,
  input  logic [OP_W-1:0]    cmd_rop,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [ADDR_W-1:0]  cfg_pitch,
  input  logic [1:0]         cfg_pix_size,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               busy,
  output logic               done,
  output logic               err
);
  import rfe_pkg::*;

  localparam logic [OP_W-1:0] FIRST_BAD = OP_W'(NUM_CODES);

  fill_state_e       state_q, state_d;
  logic [3:0]        code_q;
  logic [DATA_W-1:0] color_q;
  logic              need_dst_q;
  logic              err_q;

  logic accept, cmd_bad, cmd_empty, cmd_keep, fast_path, walk_last;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign cmd_bad   = (cmd_rop >= FIRST_BAD);
  assign cmd_empty = (cmd_w == '0) || (cmd_h == '0);
  assign cmd_keep  = (cmd_rop[3:0] == CODE_KEEP_DST);
  assign fast_path = cmd_bad || cmd_empty || cmd_keep;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (fast_path)                        state_d = ST_FIN;
          else if (code_reads_dst(cmd_rop[3:0])) state_d = ST_READ;
          else                                  state_d = ST_WRITE;
        end
      end
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: begin
        if (walk_last)       state_d = ST_FIN;
        else if (need_dst_q) state_d = ST_READ;
        else                 state_d = ST_WRITE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      code_q     <= '0;
      color_q    <= '0;
      need_dst_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        code_q     <= cmd_rop[3:0];
        color_q    <= cmd_color;
        need_dst_q <= code_reads_dst(cmd_rop[3:0]);
        err_q      <= cmd_bad;
      end else if (state_q == ST_FIN) begin
        err_q <= 1'b0;
      end
    end
  end

  rfe_walker #(
    .ADDR_W  (ADDR_W),
    .COORD_W (COORD_W)
  ) u_walker (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .step   (state_q == ST_WRITE),
    .base   (cfg_base),
    .pitch  (cfg_pitch),
    .x      (cmd_x),
    .y      (cmd_y),
    .w      (cmd_w),
    .h      (cmd_h),
    .nbytes (size_to_bytes(cfg_pix_size)),
    .addr   (mem_addr),
    .last   (walk_last)
  );

  rfe_logic_unit #(
    .DATA_W (DATA_W)
  ) u_logic (
    .code (code_q),
    .src  (color_q),
    .dst  (mem_rdata),
    .res  (mem_wdata)
  );

  assign mem_rd_en = (state_q == ST_READ);
  assign mem_wr_en = (state_q == ST_WRITE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign err       = err_q;

  // R5: rejected codes finish next cycle, flagged, with no memory traffic.
  p_reject_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_bad) |=> (done && err && !mem_rd_en && !mem_wr_en));

  // R6: empty rectangles finish next cycle with no traffic.
  p_empty_quick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_empty && !cmd_bad) |=> (done && !err && !mem_rd_en && !mem_wr_en));

  // R7: the keep-destination code finishes next cycle with no traffic.
  p_keep_quick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_keep && !cmd_bad) |=> (done && !mem_rd_en && !mem_wr_en));

  // R9: every read is followed by the write of the same pixel.
  p_read_then_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (mem_wr_en && !mem_rd_en && $stable(mem_addr)));

  // R8: destination-independent codes never read.
  p_no_read_wo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !fast_path && !code_reads_dst(cmd_rop[3:0])) |=> (mem_wr_en && !mem_rd_en));

  // R10: done is a single pulse and the engine is idle right after.
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy && cmd_ready));

  // R5: the error flag only appears with done.
  p_err_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R1: a started command holds the engine busy until it finishes.
  p_hold_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && !cmd_ready));

endmodule

// File: tb/tb_rfe_rect_fill.sv
`timescale 1ns/1ps
module tb_rfe_rect_fill;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 16;
  localparam int COORD_W   = 8;
  localparam int OP_W      = 5;
  localparam int MEM_BYTES = 1024;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n;
  logic               cmd_valid, cmd_ready;
  logic [DATA_W-1:0]  cmd_color;
  logic [COORD_W-1:0] cmd_x, cmd_y, cmd_w, cmd_h;
  logic [OP_W-1:0]    cmd_rop;
  logic [ADDR_W-1:0]  cfg_base, cfg_pitch;
  logic [1:0]         cfg_pix_size;
  logic               mem_rd_en, mem_wr_en;
  logic [ADDR_W-1:0]  mem_addr;
  logic [DATA_W-1:0]  mem_wdata, mem_rdata;
  logic               busy, done, err;

  rfe_rect_fill #(
    .DATA_W (DATA_W), .ADDR_W (ADDR_W), .COORD_W (COORD_W), .OP_W (OP_W)
  ) dut (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_color (cmd_color), .cmd_x (cmd_x), .cmd_y (cmd_y),
    .cmd_w (cmd_w), .cmd_h (cmd_h), .cmd_rop (cmd_rop),
    .cfg_base (cfg_base), .cfg_pitch (cfg_pitch), .cfg_pix_size (cfg_pix_size),
    .mem_rd_en (mem_rd_en), .mem_wr_en (mem_wr_en), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
    .busy (busy), .done (done), .err (err)
  );

  logic [7:0] ram     [MEM_BYTES];
  logic [7:0] ref_img [MEM_BYTES];
  int cur_pb = 4;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int checks = 0;
  int failures = 0;

  // Synchronous memory model: one-cycle read latency, pixel-wide writes.
  always @(posedge clk) begin
    if (mem_wr_en) begin
      for (int b = 0; b < 4; b++)
        if (b < cur_pb) ram[(int'(mem_addr) + b) % MEM_BYTES] = mem_wdata[8*b +: 8];
      wr_cnt++;
    end
    if (mem_rd_en) begin
      mem_rdata <= {ram[(int'(mem_addr) + 3) % MEM_BYTES], ram[(int'(mem_addr) + 2) % MEM_BYTES],
                    ram[(int'(mem_addr) + 1) % MEM_BYTES], ram[int'(mem_addr) % MEM_BYTES]};
      rd_cnt++;
    end
  end

  function automatic logic [31:0] rop_ref(input int code, input logic [31:0] s, input logic [31:0] d);
    case (code)
      0:  return 32'h0;
      1:  return s & d;
      2:  return s & ~d;
      3:  return s;
      4:  return ~s & d;
      5:  return d;
      6:  return s ^ d;
      7:  return s | d;
      8:  return ~s & ~d;
      9:  return ~(s ^ d);
      10: return ~d;
      11: return s | ~d;
      12: return ~s;
      13: return ~s | d;
      14: return ~s | ~d;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [31:0] color, input int x, input int y, input int w,
                         input int h, input int rop, input int psel, input int base,
                         input int pitch, input bit junk);
    int pb, n, exp_lat, exp_rd, exp_wr, k, mism_at;
    bit rejected, empty, keep, wonly, seen, busy_ok, err_seen;
    string lat_tag;
    pb       = (psel >= 2) ? 4 : (1 << psel);
    n        = w * h;
    rejected = (rop >= 16);
    empty    = (w == 0) || (h == 0);
    keep     = (rop == 5);
    wonly    = (rop == 0) || (rop == 3) || (rop == 12) || (rop == 15);
    if (rejected)   begin exp_lat = 1; lat_tag = "R5"; exp_rd = 0; exp_wr = 0; end
    else if (empty) begin exp_lat = 1; lat_tag = "R6"; exp_rd = 0; exp_wr = 0; end
    else if (keep)  begin exp_lat = 1; lat_tag = "R7"; exp_rd = 0; exp_wr = 0; end
    else if (wonly) begin exp_lat = n + 1; lat_tag = "R8"; exp_rd = 0; exp_wr = n; end
    else            begin exp_lat = 2 * n + 1; lat_tag = "R9"; exp_rd = n; exp_wr = n; end

    if (exp_wr != 0) begin
      for (int j = 0; j < h; j++) begin
        for (int i = 0; i < w; i++) begin
          int a;
          logic [31:0] d, r;
          a = base + (y + j) * pitch + (x + i) * pb;
          d = '0;
          for (int b = 0; b < pb; b++) d[8*b +: 8] = ref_img[(a + b) % MEM_BYTES];
          r = rop_ref(rop, color, d);
          for (int b = 0; b < pb; b++) ref_img[(a + b) % MEM_BYTES] = r[8*b +: 8];
        end
      end
    end

    @(negedge clk);
    cur_pb       = pb;
    cmd_color    = color;
    cmd_x        = COORD_W'(x);
    cmd_y        = COORD_W'(y);
    cmd_w        = COORD_W'(w);
    cmd_h        = COORD_W'(h);
    cmd_rop      = OP_W'(rop);
    cfg_base     = ADDR_W'(base);
    cfg_pitch    = ADDR_W'(pitch);
    cfg_pix_size = 2'(psel);
    cmd_valid    = 1'b1;
    rd_cnt       = 0;
    wr_cnt       = 0;
    check(cmd_ready === 1'b1, "R1", "ready while idle", 32'(cmd_ready), 32'd1);
    @(posedge clk);
    k = 0; seen = 0; busy_ok = 1; err_seen = 0;
    while (!seen && k < 400) begin
      @(negedge clk);
      k++;
      if (junk) begin
        // R1: fields offered while busy must be ignored.
        cmd_rop      = OP_W'(20);
        cmd_color    = ~color;
        cmd_x        = '0;
        cmd_y        = '0;
        cmd_w        = COORD_W'(9);
        cmd_h        = COORD_W'(9);
        cfg_pix_size = 2'd2;
        cfg_pitch    = ADDR_W'(3);
      end else begin
        cmd_valid = 1'b0;
      end
      if (!busy || cmd_ready) busy_ok = 0;
      if (done) begin
        seen = 1;
        err_seen = err;
        cmd_valid = 1'b0;
      end
    end
    check(seen && k == exp_lat, lat_tag, "done cycle after accept", 32'(k), 32'(exp_lat));
    check(err_seen == rejected, "R5", "err at done", 32'(err_seen), 32'(rejected));
    check(busy_ok, "R10", "busy high and ready low until done", 32'(busy_ok), 32'd1);
    @(negedge clk);
    check(!done && !busy, "R10", "done pulse then idle", {30'd0, done, busy}, 32'd0);
    check(rd_cnt == exp_rd, wonly ? "R8" : "R9", "read count", 32'(rd_cnt), 32'(exp_rd));
    check(wr_cnt == exp_wr, "R4", "write count", 32'(wr_cnt), 32'(exp_wr));
    mism_at = -1;
    for (int i = 0; i < MEM_BYTES; i++)
      if (mism_at < 0 && ram[i] !== ref_img[i]) mism_at = i;
    if (mism_at < 0)
      check(1'b1, junk ? "R1" : "R2", "image", 32'd0, 32'd0);
    else
      check(1'b0, junk ? "R1" : "R2", $sformatf("R3 image byte %0d", mism_at),
            32'(ram[mism_at]), 32'(ref_img[mism_at]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_color = '0; cmd_x = '0; cmd_y = '0; cmd_w = '0; cmd_h = '0; cmd_rop = '0;
    cfg_base = '0; cfg_pitch = '0; cfg_pix_size = '0;
    mem_rdata = '0;
    for (int i = 0; i < MEM_BYTES; i++) begin
      ram[i]     = 8'((i * 37) ^ ((i >> 3) * 11) ^ 8'h5C);
      ref_img[i] = ram[i];
    end
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready === 1'b1, "R11", "ready after reset", 32'(cmd_ready), 32'd1);
    check({busy, done, err} === 3'b000, "R11", "status after reset", 32'({busy, done, err}), 32'd0);
    check({mem_rd_en, mem_wr_en} === 2'b00, "R11", "memory idle after reset",
          32'({mem_rd_en, mem_wr_en}), 32'd0);

    // R2 R3 R4 R8 R9: every code at every pixel-size code, varied rectangles.
    for (int ps = 0; ps < 4; ps++) begin
      for (int rop = 0; rop < 16; rop++) begin
        run_cmd(32'h5A3C_96E1 ^ {4{8'(rop * 17 + ps)}}, rop % 4, (rop + ps) % 3,
                1 + (rop % 5), 1 + ((rop + ps) % 3), rop, ps, 16 + 4 * ps, 40, 1'b0);
      end
    end
    // R3: wider rectangle, larger pitch.
    run_cmd(32'hDEAD_BEEF, 2, 1, 9, 4, 6, 1, 300, 52, 1'b0);
    run_cmd(32'h0F0F_F0F0, 0, 0, 12, 2, 12, 0, 600, 20, 1'b0);
    // R5: unsupported codes.
    run_cmd(32'hFFFF_FFFF, 1, 1, 3, 3, 16, 2, 16, 40, 1'b0);
    run_cmd(32'h1234_5678, 0, 0, 2, 2, 31, 0, 16, 40, 1'b0);
    // R6: zero extents.
    run_cmd(32'hAAAA_AAAA, 1, 1, 0, 3, 7, 2, 16, 40, 1'b0);
    run_cmd(32'hAAAA_AAAA, 1, 1, 4, 0, 15, 1, 16, 40, 1'b0);
    // R7: keep-destination code over a large rectangle.
    run_cmd(32'h5555_5555, 0, 0, 8, 5, 5, 2, 16, 40, 1'b0);
    // R1: junk offered during a busy read-modify-write and a write-only command.
    run_cmd(32'hC3C3_3C3C, 1, 2, 3, 2, 9, 2, 16, 40, 1'b1);
    run_cmd(32'h7E81_18E7, 0, 1, 4, 2, 3, 1, 400, 40, 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule